// File: doc/BRIEF.md
# Card Response Turnaround Timer

This block sets the minimum turnaround between the end of a reader pause and the first response bit of an emulated proximity card on a 13.56 MHz link. It runs on the falling edge of the sample clock. While listen mode is on and the demodulated reader carrier is absent, its tick counter is held at zero. When the carrier returns, the counter starts counting ticks.

Partway through the turnaround the block raises an early ready indicator. This tells a host processor that it may begin supplying response bits. The block divides time into 16-tick bit slots, aligned to the end of the pause. It samples the host bit at each slot boundary. Once the host's first `1` bit arrives, every sampled bit goes into a 32-location delay line, and a pointer counts how many bits are waiting.

When the full frame delay has elapsed, the pointer stops moving. From then on, the line releases one bit per slot on the modulation output. The first released bit lands on the first slot boundary after the delay, however early the host started. Any further delay beyond the frame delay is left to the host.

Top module: `frame_delay_gate`

## Requirements
- R1: While `listen_i` is 1 and `carrier_i` is 0 (a pause), the tick count, the slot phase, the buffered-bit pointer and `mod_o` are cleared, and `ready_o` and `elapsed_o` read 0 one tick later. Counting restarts on the first falling edge after `carrier_i` returns to 1.
- R2: `elapsed_o` reads 1 from the 1172nd falling edge after the pause ends, and not before. The counter saturates instead of wrapping, so `elapsed_o` stays 1 for as long as no new pause occurs, including beyond 2048 ticks.
- R3: `ready_o` reads 1 from the 647th falling edge after the pause ends, and not before. It stays 1 until the next pause.
- R4: A low `carrier_i` while `listen_i` is 0 has no effect: the count keeps running, and `ready_o` and `elapsed_o` keep their timing.
- R5: Slot boundaries fall on every 16th falling edge after the pause ends (edges 16, 32, ...). `resp_bit_i` is sampled only there, and `mod_o` changes only there. Before the delay elapses, buffering starts at the first sampled `1`. Each sampled bit after that increments the pointer.
- R6: When the first response bit is sampled before the delay elapses, the response bits appear on `mod_o` in order, one per slot, with the first one on the first slot boundary after the delay (edge 1184).
- R7: When the first response bit is sampled after the delay has elapsed, each bit appears on `mod_o` at the same slot boundary where it is sampled, with no added delay.
- R8: `overflow_o` is set when a bit is sampled before the delay elapses while 31 bits are already buffered. The flag is sticky through later pauses and is cleared only by reset. A response starting at slot 43 (edge 688) never sets it. A response starting at slot 42 sets it at edge 1168.
- R9: While `rst_ni` is low, all outputs read 0.
- R10: `mod_o` stays 0 whenever `elapsed_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock; all state advances on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier_i | input | 1 | Demodulated reader carrier level (0 = pause) |
| listen_i | input | 1 | Listen mode; enables the pause to clear the timer |
| resp_bit_i | input | 1 | Response bit level from the host, sampled at slot boundaries |
| ready_o | output | 1 | Early indicator: the host may start sending |
| elapsed_o | output | 1 | Frame delay has elapsed |
| mod_o | output | 1 | Delayed modulation bit, one per slot |
| overflow_o | output | 1 | Sticky: a bit arrived with the delay line full |

## Verification
The hardest state to reach from the ports is a delay line that is exactly full at the moment the delay elapses. In that state the pointer sits at its last location and the oldest stored bit must come out first.

The stimulus releases the pause at a known edge and counts ticks from there. It starts the response at slot 43, which fills the line exactly. It then starts one slot earlier, at slot 42, which pushes one bit past capacity at edge 1168.

A late start at slot 80 exercises the pass-through path, where the pointer is zero. A long run with the carrier low and listen off shows both that the pause is ignored and that the counter saturates.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

  localparam int unsigned FDT_TICKS_DEF   = 1172;
  localparam int unsigned READY_TICKS_DEF = 647;
  localparam int unsigned SLOT_TICKS_DEF  = 16;
  localparam int unsigned DEPTH_DEF       = 32;
  localparam int unsigned CNT_W_DEF       = 11;

  // timer status handed to the delay line and to the top outputs
  typedef struct packed {
    logic clr;
    logic slot_end;
    logic ready;
    logic elapsed;
  } tmr_stat_t;

endpackage

// File: rtl/fdt_rst_sync.sv
module fdt_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/fdt_tick_timer.sv
module fdt_tick_timer
  import fdt_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned FDT_TICKS   = FDT_TICKS_DEF,
  parameter int unsigned READY_TICKS = READY_TICKS_DEF,
  parameter int unsigned SLOT_TICKS  = SLOT_TICKS_DEF
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      carrier_i,
  input  logic      listen_i,
  output tmr_stat_t stat_o
);

  localparam int unsigned PH_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] FDT_CNT = CNT_W'(FDT_TICKS);
  localparam logic [CNT_W-1:0] RDY_CNT = CNT_W'(READY_TICKS);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(SLOT_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             pause;
  logic             slot_end;
  logic             cnt_en;

  // next state
  always_comb begin
    pause    = listen_i & ~carrier_i;
    slot_end = (ph_q == PH_LAST);
    cnt_en   = (cnt_q != CNT_MAX);
    cnt_d    = cnt_q;
    ph_d     = ph_q;
    if (pause) begin
      cnt_d = '0;
      ph_d  = '0;
    end else begin
      if (cnt_en) begin
        cnt_d = cnt_q + 1'b1;
      end
      if (slot_end) begin
        ph_d = '0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign stat_o.clr      = pause;
  assign stat_o.slot_end = slot_end & ~pause;
  assign stat_o.ready    = (cnt_q >= RDY_CNT);
  assign stat_o.elapsed  = (cnt_q >= FDT_CNT);

  // R1
  pause_clr_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    pause |=> (!stat_o.ready && !stat_o.elapsed));

  // R3
  ready_first_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    stat_o.elapsed |-> stat_o.ready);

  // R2
  elapsed_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (stat_o.elapsed && !pause) |=> stat_o.elapsed);

  // R3
  ready_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (stat_o.ready && !pause) |=> stat_o.ready);

endmodule

// File: rtl/fdt_delay_line.sv
module fdt_delay_line
  import fdt_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic slot_end_i,
  input  logic elapsed_i,
  input  logic bit_i,
  output logic mod_o,
  output logic ovf_o
);

  localparam int unsigned PTR_W    = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  // DEPTH-1 stored bits plus the live input form the DEPTH-location line
  logic [DEPTH-2:0] store_q, store_d;
  logic [DEPTH-1:0] line;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             started_q, started_d;
  logic             mod_q, mod_d;
  logic             ovf_q, ovf_d;
  logic             take;

  // next state
  always_comb begin
    line      = {store_q, bit_i};
    store_d   = store_q;
    ptr_d     = ptr_q;
    started_d = started_q;
    mod_d     = mod_q;
    ovf_d     = ovf_q;
    take      = 1'b0;
    if (clr_i) begin
      ptr_d     = '0;
      started_d = 1'b0;
      mod_d     = 1'b0;
    end else if (slot_end_i) begin
      store_d = line[DEPTH-2:0];
      if (elapsed_i) begin
        mod_d = line[ptr_q];
      end else begin
        take = started_q | bit_i;
        if (take) begin
          started_d = 1'b1;
          if (ptr_q == PTR_LAST) begin
            ovf_d = 1'b1;
          end else begin
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
    end
  end

  // registers
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q   <= '0;
      ptr_q     <= '0;
      started_q <= 1'b0;
      mod_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      store_q   <= store_d;
      ptr_q     <= ptr_d;
      started_q <= started_d;
      mod_q     <= mod_d;
      ovf_q     <= ovf_d;
    end
  end

  assign mod_o = mod_q;
  assign ovf_o = ovf_q;

  // R8
  ovf_sticky_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);

  // R6
  ptr_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (elapsed_i && !clr_i) |=> $stable(ptr_q));

  // R10
  mod_quiet_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !elapsed_i |-> !mod_q);

  // R5
  mod_slot_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!slot_end_i && !clr_i) |=> $stable(mod_q));

endmodule

// File: rtl/frame_delay_gate.sv
module frame_delay_gate
  import fdt_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned FDT_TICKS   = FDT_TICKS_DEF,
  parameter int unsigned READY_TICKS = READY_TICKS_DEF,
  parameter int unsigned SLOT_TICKS  = SLOT_TICKS_DEF,
  parameter int unsigned DEPTH       = DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  input  logic listen_i,
  input  logic resp_bit_i,
  output logic ready_o,
  output logic elapsed_o,
  output logic mod_o,
  output logic overflow_o
);

  logic      rst_sync_n;
  tmr_stat_t stat;

  fdt_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  fdt_tick_timer #(
    .CNT_W       (CNT_W),
    .FDT_TICKS   (FDT_TICKS),
    .READY_TICKS (READY_TICKS),
    .SLOT_TICKS  (SLOT_TICKS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .carrier_i (carrier_i),
    .listen_i  (listen_i),
    .stat_o    (stat)
  );

  fdt_delay_line #(
    .DEPTH (DEPTH)
  ) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .clr_i      (stat.clr),
    .slot_end_i (stat.slot_end),
    .elapsed_i  (stat.elapsed),
    .bit_i      (resp_bit_i),
    .mod_o      (mod_o),
    .ovf_o      (overflow_o)
  );

  assign ready_o   = stat.ready;
  assign elapsed_o = stat.elapsed;

endmodule

// File: tb/frame_delay_gate_tb_top.sv
module frame_delay_gate_tb_top;

  localparam int FLEN = 16;
  localparam logic [FLEN-1:0] FRAME = 16'hB3A5; // sent LSB first, bit 0 is 1

  logic clk = 1'b0;
  logic rst_n, carrier, listen, resp_bit;
  logic ready, elapsed, mod, overflow;

  int n_chk = 0;
  int n_fail = 0;
  int tick = 0;
  int frame_k0 = -1;
  bit push_en = 1'b0;
  bit mon_en = 1'b0;
  logic exp_q[$];
  event sample_ev;

  always #5 clk = ~clk;

  frame_delay_gate dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .carrier_i  (carrier),
    .listen_i   (listen),
    .resp_bit_i (resp_bit),
    .ready_o    (ready),
    .elapsed_o  (elapsed),
    .mod_o      (mod),
    .overflow_o (overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", req, what, act, exp, tick);
    end
  endtask

  // driver: schedules response bits and pushes expected outputs
  task automatic drive_frame();
    if (frame_k0 > 0) begin
      for (int i = 0; i < FLEN; i++) begin
        if (tick == 16 * (frame_k0 - 1 + i)) resp_bit = FRAME[i];
        if (push_en && tick == 16 * (frame_k0 + i)) exp_q.push_back(FRAME[i]);
      end
      if (tick == 16 * (frame_k0 - 1 + FLEN)) resp_bit = 1'b0;
    end
  endtask

  // one falling edge; returns at the following rising edge
  task automatic step();
    @(negedge clk);
    @(posedge clk);
    tick++;
    drive_frame();
    -> sample_ev;
  endtask

  task automatic run_to(input int t);
    while (tick < t) step();
  endtask

  task automatic pause_release(input int n, input int k0, input bit scored);
    frame_k0 = -1;
    resp_bit = 1'b0;
    listen = 1'b1;
    carrier = 1'b0;
    repeat (n) step();
    exp_q.delete();
    carrier = 1'b1;
    tick = 0;
    frame_k0 = k0;
    push_en = scored;
    mon_en = scored;
  endtask

  // monitor: compares released bits against the scoreboard (R6, R7)
  always @(sample_ev) begin
    if (mon_en && tick >= 16 * 74 + 8 && (tick % 16) == 8 && exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      chk(mod == e, "R6/R7", "mod_o bit", int'(mod), int'(e));
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; carrier = 1'b0; listen = 1'b0; resp_bit = 1'b0;
    repeat (4) @(posedge clk);
    // R9 reset state
    chk(!ready && !elapsed && !mod && !overflow, "R9", "outputs in reset",
        int'({ready, elapsed, mod, overflow}), 0);
    rst_n = 1'b1;
    repeat (5) step();

    // scenario A: early host start at slot 50
    pause_release(20, 50, 1'b1);
    chk(!ready && !elapsed, "R1", "ready/elapsed after pause", int'({ready, elapsed}), 0);
    chk(!mod, "R10", "mod after pause", int'(mod), 0);
    run_to(646);  chk(!ready, "R3", "ready at 646", int'(ready), 0);
    run_to(647);  chk(ready,  "R3", "ready at 647", int'(ready), 1);
    run_to(1171); chk(!elapsed, "R2", "elapsed at 1171", int'(elapsed), 0);
    run_to(1172); chk(elapsed,  "R2", "elapsed at 1172", int'(elapsed), 1);
    run_to(1180); chk(!mod, "R5", "mod held before slot 74", int'(mod), 0);
    run_to(16 * 74 + 16 * 17);
    chk(exp_q.size() == 0, "R6", "all bits released", exp_q.size(), 0);
    chk(!overflow, "R8", "no overflow start 50", int'(overflow), 0);

    // scenario B: start at slot 43 fills the line exactly
    pause_release(1, 43, 1'b1);
    chk(!ready, "R1", "ready drops one tick into pause", int'(ready), 0);
    run_to(16 * 74 + 16 * 17);
    chk(exp_q.size() == 0, "R6", "full line drained", exp_q.size(), 0);
    chk(!overflow, "R8", "no overflow start 43", int'(overflow), 0);

    // scenario C: late host start, pass-through
    pause_release(3, 80, 1'b1);
    run_to(16 * 80 + 16 * 17);
    chk(exp_q.size() == 0, "R7", "late bits released", exp_q.size(), 0);

    // scenario D: start at slot 42 overflows at edge 1168
    pause_release(3, 42, 1'b0);
    run_to(1167); chk(!overflow, "R8", "overflow before 1168", int'(overflow), 0);
    run_to(1168); chk(overflow,  "R8", "overflow at 1168", int'(overflow), 1);
    pause_release(10, -1, 1'b0);
    chk(overflow, "R8", "overflow sticky across pause", int'(overflow), 1);

    // scenario E: pause ignored outside listen mode, counter saturates
    run_to(700);
    listen = 1'b0;
    carrier = 1'b0;
    run_to(1171);
    chk(ready && !elapsed, "R4", "no clear without listen", int'({ready, elapsed}), 2);
    run_to(1172); chk(elapsed, "R4", "elapsed timing kept", int'(elapsed), 1);
    run_to(2300); chk(elapsed, "R2", "saturated, no wrap", int'(elapsed), 1);
    carrier = 1'b1;

    // reset clears everything, including the sticky flag
    rst_n = 1'b0;
    step();
    chk(!ready && !elapsed && !mod && !overflow, "R9", "outputs after reset",
        int'({ready, elapsed, mod, overflow}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule